// File: doc/BRIEF.md
# Per-Core Banked Register Window Router

This block sits between a 32-bit register bus shared by up to four cores and an array of identical per-core peripheral instances, one instance per core. Each request carries the identifier of the core that issued it. The address space is divided into windows of 32 bytes each. Window 0 is an alias: it reaches the instance that belongs to the requesting core. Window k+1 reaches the instance of core k, whichever core issues the access.

The router decodes each request and checks it for errors. It routes a legal write to exactly one instance. It returns read data one cycle later and gathers the instances' interrupt lines into one vector ordered by core index.

Every illegal request is dropped: a partial-width access, a misaligned address, an address past the last implemented window, or an alias access carrying a core ID at or above the configured core count. For such a request the response reads as zero and the error flag pulses for one cycle.

The instances are register stubs:
- Word offsets 0x00 to 0x18 are plain read/write storage.
- Offset 0x1C holds the instance's interrupt level in bit 0, which drives its interrupt output.

Top module: `core_window_router`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsp_valid`, `rsp_err` and `irq` are 0. Every instance register reads as 0 after reset.
- R2: An access to window k+1 (address bits [7:5] = k+1) reaches the instance of core k, whatever the value of `req_core`.
- R3: An access to window 0 reaches the instance whose index equals `req_core`, when `req_core` is below `NUM_CORES`.
- R4: An access to window 0 with `req_core` >= `NUM_CORES` gives `rsp_err` = 1 and `rsp_rdata` = 0, and it changes no instance register.
- R5: Only `req_size` = 2'b10 (a 32-bit access) at an address with bits [1:0] = 0 is legal. Any other size or alignment gives `rsp_err` = 1 and `rsp_rdata` = 0, and it writes nothing.
- R6: An access to a window above `NUM_CORES` gives `rsp_err` = 1 and `rsp_rdata` = 0, and it writes nothing.
- R7: A request taken on a clock edge produces `rsp_valid` = 1 for exactly the following cycle. `rsp_err` is 1 only together with `rsp_valid`.
- R8: `irq[k]` follows bit 0 of the last legal write to offset 0x1C of instance k. That offset reads back as that bit, with the upper bits zero.
- R9: A storage word (offsets 0x00 to 0x18) reads back the last value written to it in the same instance. A write to one instance leaves every other instance unchanged.
- R10: Read data is the selected register's value before any write on the same edge. A legal write returns `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: bits [7:5] give the window, [4:2] the word, [1:0] the alignment |
| req_size | input | 2 | Access size code, 2'b10 = 32 bits |
| req_core | input | CORE_ID_W | Identifier of the requesting core |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was illegal |
| rsp_rdata | output | DATA_W | Read data, zero on writes and errors |
| irq | output | NUM_CORES | Interrupt outputs, bit k from the instance of core k |

## Verification
The hardest case to reach from the ports is an alias access whose core ID is out of range, followed by proof that nothing changed. Every instance must be read back in full through the fixed windows afterwards, because a wrongly routed write could land in any of them.

The bench therefore runs with three cores and a 3-bit core ID, so that IDs 3 through 7 are all illegal. It first fills every storage word of every instance with a distinct pattern. It then fires writes at the alias window from each illegal ID. Finally it sweeps all windows and words and compares each against an arithmetic model.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  localparam int MAX_CORES = 4;
  localparam int IDX_W     = 2;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic             legal;
    logic             err;
    logic [IDX_W-1:0] tgt;
    logic [2:0]       word;
  } route_t;
endpackage

// File: rtl/cwr_decode.sv
module cwr_decode #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int CORE_ID_W = 3,
  parameter int WIN_BYTES = 32
) (
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [CORE_ID_W-1:0] req_core,
  output cwr_pkg::route_t      route,
  output logic [NUM_CORES-1:0] sel
);
  import cwr_pkg::*;
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int WIN_W = ADDR_W - OFF_W;

  logic [WIN_W-1:0] win;
  logic             is_alias, bad_fmt, bad_win, bad_core;

  always_comb begin
    win        = req_addr[ADDR_W-1:OFF_W];
    is_alias   = (win == '0);
    bad_fmt    = (req_size != SIZE_WORD) || (req_addr[1:0] != 2'b00);
    bad_win    = (int'(win) > NUM_CORES);
    bad_core   = is_alias && (int'(req_core) >= NUM_CORES);
    route.word = req_addr[4:2];
    if (is_alias) route.tgt = req_core[IDX_W-1:0];
    else          route.tgt = IDX_W'(win - WIN_W'(1));
    route.legal = req_valid && !bad_fmt && !bad_win && !bad_core;
    route.err   = req_valid && !route.legal;
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_sel
    assign sel[i] = route.legal && (int'(route.tgt) == i);
  end
endmodule

// File: rtl/cwr_regstub.sv
module cwr_regstub #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] word,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     irq
);
  localparam int STORE = WORDS - 1;

  logic [DATA_W-1:0] mem [STORE];
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < STORE; j++) mem[j] <= '0;
      irq_q <= 1'b0;
    end else if (wr_en) begin
      if (int'(word) == STORE) irq_q <= wr_data[0];
      for (int j = 0; j < STORE; j++)
        if (int'(word) == j) mem[j] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(word) == STORE) rd_data = {{(DATA_W-1){1'b0}}, irq_q};
    for (int j = 0; j < STORE; j++)
      if (int'(word) == j) rd_data = mem[j];
  end

  assign irq = irq_q;
endmodule

// File: rtl/cwr_resp.sv
module cwr_resp #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic                              legal,
  input  logic                              err,
  input  logic [NUM_CORES-1:0]              sel,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  rd_bus,
  output logic                              rsp_valid,
  output logic                              rsp_err,
  output logic [DATA_W-1:0]                 rsp_rdata
);
  logic [DATA_W-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (sel[i]) mux_d = rd_bus[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err;
      rsp_rdata <= (legal && !req_write) ? mux_d : '0;
    end
  end
endmodule

// File: rtl/core_window_router.sv
module core_window_router #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int CORE_ID_W = 3,
  parameter int DATA_W    = 32,
  parameter int WIN_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [CORE_ID_W-1:0] req_core,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_CORES-1:0] irq
);
  localparam int WORDS = WIN_BYTES / 4;

  cwr_pkg::route_t                   route;
  logic [NUM_CORES-1:0]              sel;
  logic [NUM_CORES-1:0][DATA_W-1:0]  rd_bus;

  cwr_decode #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W),
    .CORE_ID_W(CORE_ID_W), .WIN_BYTES(WIN_BYTES)
  ) u_dec (
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_core(req_core), .route(route), .sel(sel)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_inst
    cwr_regstub #(.DATA_W(DATA_W), .WORDS(WORDS)) u_stub (
      .clk(clk), .rst(rst),
      .wr_en(sel[i] && req_write),
      .word(route.word[$clog2(WORDS)-1:0]),
      .wr_data(req_wdata),
      .rd_data(rd_bus[i]),
      .irq(irq[i])
    );
  end

  cwr_resp #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .legal(route.legal), .err(route.err), .sel(sel), .rd_bus(rd_bus),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/cwr_checker.sv
module cwr_checker #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int CORE_ID_W = 3,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [1:0]           req_size,
  input logic [CORE_ID_W-1:0] req_core,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_CORES-1:0] irq
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R7
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R7
  AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid); // R7
  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0)); // R4
  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != 2'b10) |=> rsp_err); // R5
  AST_BAD_CORE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[ADDR_W-1:5] == '0 && int'(req_core) >= NUM_CORES)
      |=> rsp_err); // R4
  AST_BAD_WIN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_addr[ADDR_W-1:5]) > NUM_CORES) |=> rsp_err); // R6
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(irq)); // R8
  AST_WRITE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == '0)); // R10
endmodule

bind core_window_router cwr_checker #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W),
  .CORE_ID_W(CORE_ID_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .req_core(req_core),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq(irq)
);

// File: tb/core_window_router_test.sv
`timescale 1ns/1ps
module core_window_router_test;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [2:0]  req_core = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq;

  int errors = 0, checks = 0;
  logic [31:0] model [NC][8];
  logic [NC-1:0] irq_m = '0;

  always #5 clk = ~clk;

  core_window_router #(.NUM_CORES(NC), .ADDR_W(8), .CORE_ID_W(3)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_core(req_core),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] adr(input int win, input int word);
    return 8'((win << 5) | (word << 2));
  endfunction

  function automatic logic [31:0] pat(input int k, input int w, input int salt);
    return 32'hC000_0000 ^ 32'(salt << 16) ^ 32'(k << 8) ^ 32'(w * 3 + 1);
  endfunction

  // one request; response sampled on the next falling edge
  task automatic xfer(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                      input logic [2:0] core, input logic [31:0] wd,
                      input logic exp_err, input logic [31:0] exp_rd, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_core = core; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " rsp_err"}, 32'(rsp_err), 32'(exp_err));
    chk({req, " rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic exp_word(input int k, input int w, output logic [31:0] v);
    v = (w == 7) ? 32'(irq_m[k]) : model[k][w];
  endtask

  task automatic sweep(input string req);
    logic [31:0] e;
    for (int k = 0; k < NC; k++)
      for (int w = 0; w < 8; w++) begin
        exp_word(k, w, e);
        xfer(1'b0, adr(k + 1, w), 2'b10, 3'((k + 1) % NC), 32'h0, 1'b0, e, req);
      end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] e;
    for (int k = 0; k < NC; k++)
      for (int w = 0; w < 8; w++) model[k][w] = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(rsp_valid), 0);
    chk("R1 err in reset", 32'(rsp_err), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 32'(rsp_valid), 0);
    chk("R7 idle no response", 32'(rsp_valid), 0);
    sweep("R1 reset contents");

    // R2 R9: fill every instance via fixed windows, from a foreign core ID
    for (int k = 0; k < NC; k++)
      for (int w = 0; w < 7; w++) begin
        xfer(1'b1, adr(k + 1, w), 2'b10, 3'((k + 2) % NC), pat(k, w, 1), 1'b0, 0, "R10 write data");
        model[k][w] = pat(k, w, 1);
      end
    sweep("R2 R9 fixed windows");

    // R3: alias window follows the requester
    for (int c = 0; c < NC; c++) begin
      for (int w = 0; w < 7; w++) begin
        xfer(1'b0, adr(0, w), 2'b10, 3'(c), 0, 1'b0, model[c][w], "R3 alias read");
        xfer(1'b1, adr(0, w), 2'b10, 3'(c), pat(c, w, 2), 1'b0, 0, "R3 alias write");
        model[c][w] = pat(c, w, 2);
      end
    end
    sweep("R3 alias landed");

    // R10: back-to-back write then read of same word
    xfer(1'b1, adr(2, 3), 2'b10, 3'd0, 32'h1234_5678, 1'b0, 0, "R10 write");
    model[1][3] = 32'h1234_5678;
    xfer(1'b0, adr(2, 3), 2'b10, 3'd0, 32'hFFFF_FFFF, 1'b0, 32'h1234_5678, "R10 read");

    // R4: illegal core IDs on alias window
    for (int c = NC; c < 8; c++)
      for (int w = 0; w < 8; w++) begin
        xfer(1'b1, adr(0, w), 2'b10, 3'(c), 32'hDEAD_0001, 1'b1, 0, "R4 bad core write");
        xfer(1'b0, adr(0, w), 2'b10, 3'(c), 0, 1'b1, 0, "R4 bad core read");
      end
    chk("R4 irq untouched", 32'(irq), 32'(irq_m));

    // R5: bad sizes and misalignment
    for (int s = 0; s < 4; s++)
      if (s != 2) begin
        xfer(1'b1, adr(1, 0), 2'(s), 3'd0, 32'hBAD0_0000, 1'b1, 0, "R5 bad size write");
        xfer(1'b0, adr(1, 0), 2'(s), 3'd0, 0, 1'b1, 0, "R5 bad size read");
      end
    for (int m = 1; m < 4; m++)
      xfer(1'b1, adr(2, 1) | 8'(m), 2'b10, 3'd1, 32'hBAD1_0000, 1'b1, 0, "R5 misaligned");

    // R6: windows past the implemented ones
    for (int win = NC + 1; win < 8; win++)
      for (int w = 0; w < 8; w += 3) begin
        xfer(1'b1, adr(win, w), 2'b10, 3'd0, 32'hBAD2_0000, 1'b1, 0, "R6 bad window write");
        xfer(1'b0, adr(win, w), 2'b10, 3'd0, 0, 1'b1, 0, "R6 bad window read");
      end
    sweep("R4 R5 R6 nothing written");

    // R8: interrupt lines in core order
    for (int k = 0; k < NC; k++) begin
      xfer(1'b1, adr(k + 1, 7), 2'b10, 3'd0, 32'hFFFF_FFFF, 1'b0, 0, "R8 irq set");
      irq_m[k] = 1'b1;
      chk("R8 irq vector", 32'(irq), 32'(irq_m));
    end
    xfer(1'b1, adr(0, 7), 2'b10, 3'd1, 32'hFFFF_FFFE, 1'b0, 0, "R8 irq clear via alias");
    irq_m[1] = 1'b0;
    chk("R8 irq vector after clear", 32'(irq), 32'(irq_m));
    sweep("R8 irq readback");

    @(negedge clk);
    chk("R7 idle no response", 32'(rsp_valid), 0);
    chk("R7 idle no error", 32'(rsp_err), 0);

    // R1: reset clears everything again
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NC; k++)
      for (int w = 0; w < 8; w++) model[k][w] = '0;
    irq_m = '0;
    chk("R1 irq after second reset", 32'(irq), 0);
    sweep("R1 second reset contents");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule